// File: doc/BRIEF.md
# Capacitive Key Matrix Scan Sequencer

This block walks a touch-key matrix of 8 drive lines by 2 receive lines, one key after another, and runs one acquisition burst on each key that is switched on. A key's burst is a train of drive pulses. The length of the train comes from a per-key burst-length field. A field of zero removes that key from the scan altogether, so a frame with fewer active keys ends sooner. Each pulse holds its drive line high for a programmable dwell time and then spends one clock low with the receive line clamped. On that final low clock of a burst, the block raises an end-of-burst strobe that tells the downstream converter to take the result.

Scanning starts on a periodic frame tick. When the last active key has finished, the sequencer goes idle until the next tick. A tick that arrives while a scan is still running does not disturb the scan. Instead it sets a sticky overrun flag, which stays set until the host pulses a clear input. Burst length and dwell are captured when each burst starts, so the host can rewrite the register file at any time.

Top module: `keyscan_seq`

## Requirements
- R1: After synchronous reset, all drive outputs are 0 and the receive clamp is 1. The busy flag, the end-of-burst strobe and the overrun flag are all 0.
- R2: Keys are scanned in ascending index order. Key index k = 8·y + x. While key k is active, drive_pulse bit (k mod 8) is the only bit that may be set, and recv_sel equals k div 8.
- R3: A key whose captured burst length is B produces exactly B high pulses. burst_done is 1 on exactly one clock per burst: the low clock that follows the B-th high phase.
- R4: A key whose 8-bit burst length is zero is skipped and uses no clocks. The first high clock of the next enabled key comes on the clock right after the previous key's burst_done.
- R5: Each high phase lasts max(dwell,1) clocks and is followed by exactly one low clock. drive_pulse is one-hot during a high phase and all zero otherwise. recv_clamp is 0 during a high phase and 1 otherwise.
- R6: A frame_tick seen while idle, with at least one burst length non-zero, starts the first enabled key's high phase on the next clock.
- R7: A frame_tick seen while idle, with every burst length zero, produces no pulse and no burst_done, and the block stays idle.
- R8: A frame_tick seen while scan_busy is 1 leaves the scan unchanged and sets overrun on the next clock. overrun then stays set.
- R9: overrun is cleared only by ovr_clr. If ovr_clr coincides with an overrun-setting tick, the set wins.
- R10: The burst length and dwell are sampled on the clock a key's burst starts. Changing them during that burst does not change that burst's pulse count or phase lengths.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | Frame-start strobe |
| ovr_clr | input | 1 | Clears the overrun flag |
| burst_len | input | 128 | Per-key burst lengths, key k in bits [8k+7:8k] |
| dwell | input | 4 | High-phase length in clocks (0 treated as 1) |
| drive_pulse | output | 8 | One-hot drive-line pulses |
| recv_sel | output | 1 | Receive line of the current key |
| recv_clamp | output | 1 | Receive line clamp, high outside high phases |
| key_idx | output | 4 | Index of the current key |
| burst_done | output | 1 | End-of-burst strobe for conversion hand-off |
| scan_busy | output | 1 | Scan in progress |
| overrun | output | 1 | Sticky frame-overrun flag |

## Verification
The hardest cases to reach are mid-burst rewrites of the burst length and dwell, and frame ticks that land inside a running scan. The stimulus starts a sparse frame and waits, using the key index and drive outputs, until a chosen key is partway through its train. It then rewrites that key's length and the dwell and fires ticks, some of them together with a clear. A behavioural model builds each key's expected cycles only when that key starts, so it uses the values present at that moment. Every clock is compared against this model.

// File: rtl/keyscan_pkg.sv
package keyscan_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_t;

    typedef struct packed {
        phase_t phase;
        logic   burst_end;
    } burst_stat_t;

    // dwell of zero is stretched to one clock
    function automatic logic dwell_is_zero(input int unsigned d);
        return d == 0;
    endfunction

endpackage

// File: rtl/keyscan_key_finder.sv
module keyscan_key_finder #(
    parameter int N_KEYS = 16,
    parameter int KW     = 4
) (
    input  logic [N_KEYS-1:0] en,
    input  logic [KW:0]       from,
    output logic              found,
    output logic [KW-1:0]     idx
);
    localparam int FW = KW + 1;

    // lowest enabled key at or above 'from'
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N_KEYS - 1; i >= 0; i--) begin
            if (en[i] && (FW'(i) >= from)) begin
                found = 1'b1;
                idx   = KW'(i);
            end
        end
    end
endmodule

// File: rtl/keyscan_burst_timer.sv
module keyscan_burst_timer
    import keyscan_pkg::*;
#(
    parameter int BL_W = 8,
    parameter int DW_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [BL_W-1:0] bl_in,
    input  logic [DW_W-1:0] dwell_in,
    output burst_stat_t     stat
);
    phase_t          ph;
    logic [DW_W-1:0] dcnt;
    logic [DW_W-1:0] dlim;
    logic [BL_W-1:0] pcnt;
    logic [BL_W-1:0] plim;
    logic            last_pulse;

    assign last_pulse = (pcnt == plim);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph   <= PH_IDLE;
            dcnt <= '0;
            dlim <= '0;
            pcnt <= '0;
            plim <= '0;
        end else if (start) begin
            ph   <= PH_HIGH;
            dcnt <= '0;
            pcnt <= BL_W'(1);
            plim <= bl_in;
            dlim <= dwell_is_zero(int'(dwell_in)) ? '0 : dwell_in - 1'b1;
        end else begin
            case (ph)
                PH_HIGH: begin
                    if (dcnt == dlim) ph <= PH_LOW;
                    else              dcnt <= dcnt + 1'b1;
                end
                PH_LOW: begin
                    if (last_pulse) begin
                        ph <= PH_IDLE;
                    end else begin
                        ph   <= PH_HIGH;
                        dcnt <= '0;
                        pcnt <= pcnt + 1'b1;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        stat.phase     = ph;
        stat.burst_end = (ph == PH_LOW) && last_pulse;
    end
endmodule

// File: rtl/keyscan_seq.sv
module keyscan_seq
    import keyscan_pkg::*;
#(
    parameter int N_DRIVE = 8,
    parameter int N_RECV  = 2,
    parameter int BL_W    = 8,
    parameter int DW_W    = 4,
    localparam int N_KEYS = N_DRIVE * N_RECV,
    localparam int XW     = $clog2(N_DRIVE),
    localparam int KW     = $clog2(N_KEYS),
    localparam int YW     = KW - XW
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   frame_tick,
    input  logic                   ovr_clr,
    input  logic [N_KEYS*BL_W-1:0] burst_len,
    input  logic [DW_W-1:0]        dwell,
    output logic [N_DRIVE-1:0]     drive_pulse,
    output logic [YW-1:0]          recv_sel,
    output logic                   recv_clamp,
    output logic [KW-1:0]          key_idx,
    output logic                   burst_done,
    output logic                   scan_busy,
    output logic                   overrun
);
    logic [N_KEYS-1:0] key_en;
    logic [KW-1:0]     key_q;
    logic              first_found, next_found;
    logic [KW-1:0]     first_idx, next_idx;
    logic              launch_first, launch_next, start;
    logic [KW-1:0]     start_key;
    logic [BL_W-1:0]   bl_sel;
    burst_stat_t       stat;

    for (genvar g = 0; g < N_KEYS; g++) begin : g_en
        assign key_en[g] = |burst_len[g*BL_W +: BL_W];
    end

    keyscan_key_finder #(.N_KEYS(N_KEYS), .KW(KW)) u_first (
        .en    (key_en),
        .from  ('0),
        .found (first_found),
        .idx   (first_idx)
    );

    keyscan_key_finder #(.N_KEYS(N_KEYS), .KW(KW)) u_next (
        .en    (key_en),
        .from  ({1'b0, key_q} + 1'b1),
        .found (next_found),
        .idx   (next_idx)
    );

    assign scan_busy    = (stat.phase != PH_IDLE);
    assign launch_first = frame_tick && !scan_busy && first_found;
    assign launch_next  = stat.burst_end && next_found;
    assign start        = launch_first || launch_next;
    assign start_key    = launch_first ? first_idx : next_idx;
    assign bl_sel       = burst_len[start_key*BL_W +: BL_W];

    keyscan_burst_timer #(.BL_W(BL_W), .DW_W(DW_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .bl_in    (bl_sel),
        .dwell_in (dwell),
        .stat     (stat)
    );

    always_ff @(posedge clk) begin
        if (rst)        key_q <= '0;
        else if (start) key_q <= start_key;
    end

    always_ff @(posedge clk) begin
        if (rst)                          overrun <= 1'b0;
        else if (frame_tick && scan_busy) overrun <= 1'b1;
        else if (ovr_clr)                 overrun <= 1'b0;
    end

    for (genvar d = 0; d < N_DRIVE; d++) begin : g_drv
        assign drive_pulse[d] = (stat.phase == PH_HIGH) && (key_q[XW-1:0] == XW'(d));
    end

    assign recv_sel   = key_q[KW-1:XW];
    assign recv_clamp = (stat.phase != PH_HIGH);
    assign key_idx    = key_q;
    assign burst_done = stat.burst_end;
endmodule

// File: rtl/keyscan_seq_chk.sv
module keyscan_seq_chk #(
    parameter int N_DRIVE = 8,
    parameter int N_KEYS  = 16,
    parameter int BL_W    = 8,
    parameter int KW      = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   frame_tick,
    input logic                   ovr_clr,
    input logic [N_KEYS*BL_W-1:0] burst_len,
    input logic [N_DRIVE-1:0]     drive_pulse,
    input logic                   recv_clamp,
    input logic [KW-1:0]          key_idx,
    input logic                   burst_done,
    input logic                   scan_busy,
    input logic                   overrun
);
    logic any_en;
    assign any_en = |burst_len;

    a_r5_onehot_drive: assert property (@(posedge clk) disable iff (rst)
        $onehot0(drive_pulse));

    a_r5_clamp_off_when_driving: assert property (@(posedge clk) disable iff (rst)
        (|drive_pulse) |-> !recv_clamp);

    a_r3_done_in_low_phase: assert property (@(posedge clk) disable iff (rst)
        burst_done |-> (scan_busy && !(|drive_pulse)));

    a_r2_key_held_in_burst: assert property (@(posedge clk) disable iff (rst)
        (scan_busy && !burst_done) |=> (scan_busy && $stable(key_idx)));

    a_r6_tick_starts_scan: assert property (@(posedge clk) disable iff (rst)
        (frame_tick && !scan_busy && any_en) |=> (scan_busy && (|drive_pulse)));

    a_r7_empty_frame_idle: assert property (@(posedge clk) disable iff (rst)
        (frame_tick && !scan_busy && !any_en) |=> !scan_busy);

    a_r8_tick_sets_overrun: assert property (@(posedge clk) disable iff (rst)
        (frame_tick && scan_busy) |=> overrun);

    a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        (overrun && !ovr_clr) |=> overrun);
endmodule

bind keyscan_seq keyscan_seq_chk #(
    .N_DRIVE (N_DRIVE),
    .N_KEYS  (N_KEYS),
    .BL_W    (BL_W),
    .KW      (KW)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_tick  (frame_tick),
    .ovr_clr     (ovr_clr),
    .burst_len   (burst_len),
    .drive_pulse (drive_pulse),
    .recv_clamp  (recv_clamp),
    .key_idx     (key_idx),
    .burst_done  (burst_done),
    .scan_busy   (scan_busy),
    .overrun     (overrun)
);

// File: tb/keyscan_seq_bench.sv
module keyscan_seq_bench;
    localparam int NK = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         frame_tick = 1'b0;
    logic         ovr_clr = 1'b0;
    logic [127:0] burst_len = '0;
    logic [3:0]   dwell = 4'd1;
    logic [7:0]   drive_pulse;
    logic [0:0]   recv_sel;
    logic         recv_clamp;
    logic [3:0]   key_idx;
    logic         burst_done;
    logic         scan_busy;
    logic         overrun;

    always #10 clk = ~clk;

    keyscan_seq u_keyscan_seq (
        .clk(clk), .rst(rst), .frame_tick(frame_tick), .ovr_clr(ovr_clr),
        .burst_len(burst_len), .dwell(dwell), .drive_pulse(drive_pulse),
        .recv_sel(recv_sel), .recv_clamp(recv_clamp), .key_idx(key_idx),
        .burst_done(burst_done), .scan_busy(scan_busy), .overrun(overrun)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    typedef struct {
        bit hi;
        int key;
        bit done;
        bit busy;
    } cyc_t;

    cyc_t q[$];
    cyc_t cur;
    bit   m_ovr;

    function automatic cyc_t idle_cyc();
        cyc_t c;
        c.hi = 0; c.key = 0; c.done = 0; c.busy = 0;
        return c;
    endfunction

    function automatic int bl_of(int k);
        return int'(burst_len[k*8 +: 8]);
    endfunction

    task automatic push_key(input int from);
        int k;
        int dw;
        cyc_t c;
        k = from;
        while (k < NK && bl_of(k) == 0) k++;
        if (k >= NK) return;
        dw = (dwell == 0) ? 1 : int'(dwell);
        for (int p = 1; p <= bl_of(k); p++) begin
            for (int d = 0; d < dw; d++) begin
                c.hi = 1; c.key = k; c.done = 0; c.busy = 1;
                q.push_back(c);
            end
            c.hi = 0; c.key = k; c.done = (p == bl_of(k)); c.busy = 1;
            q.push_back(c);
        end
    endtask

    always @(posedge clk) begin
        cyc_t prev;
        if (rst) begin
            q.delete();
            cur   = idle_cyc();
            m_ovr = 0;
        end else begin
            prev = cur;
            if (frame_tick && prev.busy) m_ovr = 1;
            else if (ovr_clr)            m_ovr = 0;
            if (q.size() == 0) begin
                if (!prev.busy && frame_tick) push_key(0);
                else if (prev.done)           push_key(prev.key + 1);
            end
            if (q.size() > 0) cur = q.pop_front();
            else              cur = idle_cyc();
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        logic [7:0] exp_drv;
        if (!rst) begin
            exp_drv = cur.hi ? (8'd1 << (cur.key % 8)) : 8'd0;
            chk(drive_pulse == exp_drv, "R5", "drive_pulse", drive_pulse, exp_drv);
            chk(recv_clamp == !cur.hi, "R5", "recv_clamp", recv_clamp, !cur.hi);
            chk(scan_busy == cur.busy, "R4", "scan_busy", scan_busy, cur.busy);
            chk(burst_done == cur.done, "R3", "burst_done", burst_done, cur.done);
            if (cur.busy) begin
                chk(int'(key_idx) == cur.key, "R2", "key_idx", key_idx, cur.key);
                chk(int'(recv_sel) == cur.key / 8, "R2", "recv_sel", recv_sel, cur.key / 8);
            end
            chk(overrun == m_ovr, "R8", "overrun", overrun, m_ovr);
        end
    end

    // pulse counter for key 2 (R10)
    int  pulses_k2 = 0;
    bit  was_hi = 0;
    always @(negedge clk) begin
        if (scan_busy && key_idx == 4'd2 && (|drive_pulse) && !was_hi) pulses_k2++;
        was_hi = |drive_pulse;
    end

    // ---------------- stimulus helpers ----------------
    task automatic set_bl(input int k, input int v);
        burst_len[k*8 +: 8] = 8'(v);
    endtask

    task automatic tick();
        @(negedge clk); frame_tick = 1;
        @(negedge clk); frame_tick = 0;
    endtask

    task automatic wait_idle();
        int n;
        n = 0;
        while (scan_busy && n < 20000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(drive_pulse == 0, "R1", "drive after reset", drive_pulse, 0);
        chk(recv_clamp == 1, "R1", "clamp after reset", recv_clamp, 1);
        chk(scan_busy == 0 && burst_done == 0 && overrun == 0, "R1", "flags after reset",
            {scan_busy, burst_done, overrun}, 0);

        // R2 R6: every key one pulse, dwell 1
        for (int k = 0; k < NK; k++) set_bl(k, 1);
        dwell = 4'd1;
        @(negedge clk); frame_tick = 1;
        @(negedge clk); frame_tick = 0;
        chk(scan_busy && drive_pulse == 8'h01, "R6", "first high after tick", drive_pulse, 1);
        wait_idle();

        // R4 R5: sparse, varied lengths, dwell 3 then dwell 0
        burst_len = '0;
        set_bl(1, 3); set_bl(4, 1); set_bl(7, 2); set_bl(8, 5); set_bl(13, 2);
        dwell = 4'd3;
        tick(); wait_idle();
        dwell = 4'd0;
        tick(); wait_idle();
        dwell = 4'd15;
        set_bl(15, 2);
        tick(); wait_idle();

        // R7: all zero
        burst_len = '0;
        @(negedge clk); frame_tick = 1;
        @(negedge clk); frame_tick = 0;
        chk(!scan_busy && drive_pulse == 0 && !burst_done, "R7", "empty frame idle",
            scan_busy, 0);
        repeat (4) @(negedge clk);

        // only the last key
        set_bl(15, 3); dwell = 4'd2;
        tick(); wait_idle();

        // R8 R9: overrun
        burst_len = '0;
        set_bl(0, 4); set_bl(9, 4); dwell = 4'd2;
        tick();
        repeat (5) @(negedge clk);
        tick();
        chk(overrun == 1, "R8", "overrun after tick in scan", overrun, 1);
        wait_idle();
        chk(overrun == 1, "R8", "overrun sticky", overrun, 1);
        @(negedge clk); ovr_clr = 1;
        @(negedge clk); ovr_clr = 0;
        chk(overrun == 0, "R9", "overrun cleared", overrun, 0);
        tick();
        repeat (3) @(negedge clk);
        frame_tick = 1; ovr_clr = 1;
        @(negedge clk); frame_tick = 0; ovr_clr = 0;
        chk(overrun == 1, "R9", "set wins over clear", overrun, 1);
        wait_idle();
        @(negedge clk); ovr_clr = 1;
        @(negedge clk); ovr_clr = 0;

        // R10: rewrite length and dwell during a burst
        burst_len = '0;
        set_bl(2, 4); set_bl(5, 2); dwell = 4'd2;
        pulses_k2 = 0;
        tick();
        while (!(scan_busy && key_idx == 4'd2 && recv_clamp)) @(negedge clk);
        set_bl(2, 9); dwell = 4'd6;
        wait_idle();
        chk(pulses_k2 == 4, "R10", "pulses of key 2", pulses_k2, 4);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule